// File: doc/BRIEF.md
# Buffered Word Program Loader

This block front-ends a program engine with a small write buffer. A host on a synchronous write-strobe bus opens a buffered program sequence by writing the open code E8h to any address inside the target block. The block then takes a word-count write and a series of address/data writes into its internal buffer. After that it expects a confirm write. Once the sequence is confirmed, the buffered words go to the program engine one at a time. Each word is held on a request until the engine answers with a done pulse.

Status is reported on two byte-wide outputs. The extended status byte tells the host whether its open code was accepted. The main status byte carries a ready flag, two error flags that together mark an improper sequence, and a protect flag for locked blocks. Only word-wide data is supported. Each block's lock state is an input vector, indexed by block number.

Top module: `pbuf_loader`

## Requirements
- R1: After reset, status_o reads 80h (bit 7 ready set, all others 0) and xstatus_o reads 00h. While idle, a write whose data low byte is E8h is accepted: xstatus_o bit 7 becomes 1 and the block waits for the count write. Any other write while idle changes nothing.
- R2: A write of E8h while words are still being programmed is rejected. xstatus_o bit 7 reads 0, and the programming in progress continues unchanged.
- R3: The count write gives N-1 in data bits [7:0], and data bits [15:8] are ignored. A value above 15 is an improper sequence: status_o bits 5 and 4 are set and the block returns to idle.
- R4: Exactly N address/data writes follow the count. Each one is stored and later programmed in load order. Its program address is the block number from the open write joined with the low 16 address bits of the load write.
- R5: The write after the N loads must carry D0h in data bits [7:0], to an address in the open write's block. Otherwise status_o bits 5 and 4 are both set and nothing is programmed.
- R6: A load write whose address lies outside the open write's block makes the sequence improper when it is confirmed: status_o bits 5 and 4 are set and nothing is programmed.
- R7: When a sequence is confirmed correctly but lock_i bit [block] is 1, nothing is programmed, status_o bit 1 is set, and status_o bit 7 stays 1.
- R8: status_o bit 7 reads 0 from the cycle after a good confirm until the cycle after the engine's done for the last word.
- R9: pe_req_o stays high with pe_addr_o and pe_data_o stable until pe_done_i. Each done pulse retires exactly one word.
- R10: An accepted E8h write clears status_o bits 5, 4 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | 22 | Word address of the write |
| wr_data_i | input | 16 | Write data |
| lock_i | input | 64 | Lock state per block |
| status_o | output | 8 | Bit 7 ready, bit 5 and bit 4 improper-sequence errors, bit 1 protect |
| xstatus_o | output | 8 | Bit 7 buffer available for the last open write |
| pe_req_o | output | 1 | Program request to the engine |
| pe_addr_o | output | 22 | Word address to program |
| pe_data_o | output | 16 | Word to program |
| pe_done_i | input | 1 | Engine done pulse for the current word |

## Verification
Every status result is registered on the clock edge that samples the write, and is due one cycle after that write. The bench drives each write between edges and samples status in the half period after the next edge. The first engine request rises two cycles after a good confirm: the confirm edge launches a start pulse, and the issuer registers it on the next edge. After the done for the last word, ready returns one cycle later. A scoreboard queue receives each expected address/data pair as it is loaded. The engine model compares the request against the head of that queue while it drives done, and it counts any request that arrives with the queue empty as a failure.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CNT  = 3'd1,
    ST_LOAD = 3'd2,
    ST_CONF = 3'd3,
    ST_PROG = 3'd4
  } pbuf_state_e;

  localparam logic [7:0] OPEN_CODE = 8'hE8;
  localparam logic [7:0] CONF_CODE = 8'hD0;

  localparam int SR_READY   = 7;
  localparam int SR_ERR_ERS = 5;
  localparam int SR_ERR_PRG = 4;
  localparam int SR_PROTECT = 1;
  localparam int XSR_AVAIL  = 7;
endpackage

// File: rtl/pbuf_mem.sv
module pbuf_mem #(
  parameter int DEPTH  = 16,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [OFS_W-1:0]  wofs_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [OFS_W-1:0]  rofs_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [OFS_W-1:0]  ofs_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ofs_q[g] <= '0;
        dat_q[g] <= '0;
      end else if (we_i && widx_i == IDX_W'(g)) begin
        ofs_q[g] <= wofs_i;
        dat_q[g] <= wdata_i;
      end
    end
  end

  assign rofs_o  = ofs_q[ridx_i];
  assign rdata_o = dat_q[ridx_i];
endmodule

// File: rtl/pbuf_issue.sv
module pbuf_issue #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] last_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [IDX_W-1:0] ridx_o,
  output logic             finish_o
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;

  assign req_o    = active_q;
  assign ridx_o   = idx_q;
  assign finish_o = active_q && done_i && (idx_q == last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      last_q   <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      last_q   <= last_i;
    end else if (active_q && done_i) begin
      if (idx_q == last_q) active_q <= 1'b0;
      else                 idx_q    <= idx_q + 1'b1;
    end
  end

  // R9: one word per done, request held until done
  a_r9_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !done_i) |=> (active_q && $stable(idx_q)));
  a_r9_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && done_i && idx_q != last_q) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
  import pbuf_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int OFS_W  = 16,
  parameter int DEPTH  = 16,
  localparam int BLK_W = ADDR_W - OFS_W,
  localparam int NBLK  = 1 << BLK_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_code_i,
  input  logic [NBLK-1:0]   lock_i,
  input  logic              finish_i,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_idx_o,
  output logic              start_o,
  output logic [IDX_W-1:0]  last_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [7:0]        status_o,
  output logic [7:0]        xstatus_o
);
  pbuf_state_e      state_q;
  logic [BLK_W-1:0] blk_q;
  logic [IDX_W-1:0] last_q;
  logic [IDX_W:0]   ld_q;
  logic             bad_q;
  logic             avail_q, err_e_q, err_p_q, prot_q, start_q;

  logic [BLK_W-1:0] wr_blk;
  logic             same_blk;
  assign wr_blk   = wr_addr_i[ADDR_W-1:OFS_W];
  assign same_blk = (wr_blk == blk_q);

  assign mem_we_o  = (state_q == ST_LOAD) && wr_en_i && same_blk;
  assign mem_idx_o = ld_q[IDX_W-1:0];
  assign start_o   = start_q;
  assign last_o    = last_q;
  assign blk_o     = blk_q;

  always_comb begin
    status_o = '0;
    status_o[SR_READY]   = (state_q != ST_PROG);
    status_o[SR_ERR_ERS] = err_e_q;
    status_o[SR_ERR_PRG] = err_p_q;
    status_o[SR_PROTECT] = prot_q;
    xstatus_o = '0;
    xstatus_o[XSR_AVAIL] = avail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      blk_q   <= '0;
      last_q  <= '0;
      ld_q    <= '0;
      bad_q   <= 1'b0;
      avail_q <= 1'b0;
      err_e_q <= 1'b0;
      err_p_q <= 1'b0;
      prot_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (wr_en_i && wr_code_i == OPEN_CODE) begin
          avail_q <= 1'b1;
          err_e_q <= 1'b0;
          err_p_q <= 1'b0;
          prot_q  <= 1'b0;
          blk_q   <= wr_blk;
          state_q <= ST_CNT;
        end
        ST_CNT: if (wr_en_i) begin
          if (wr_code_i > 8'(DEPTH - 1)) begin
            err_e_q <= 1'b1;
            err_p_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            last_q  <= wr_code_i[IDX_W-1:0];
            ld_q    <= '0;
            bad_q   <= 1'b0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: if (wr_en_i) begin
          if (!same_blk) bad_q <= 1'b1;
          if (ld_q[IDX_W-1:0] == last_q) state_q <= ST_CONF;
          ld_q <= ld_q + 1'b1;
        end
        ST_CONF: if (wr_en_i) begin
          if (wr_code_i != CONF_CODE || !same_blk || bad_q) begin
            err_e_q <= 1'b1;
            err_p_q <= 1'b1;
            state_q <= ST_IDLE;
          end else if (lock_i[blk_q]) begin
            prot_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            start_q <= 1'b1;
            state_q <= ST_PROG;
          end
        end
        ST_PROG: begin
          if (wr_en_i && wr_code_i == OPEN_CODE) avail_q <= 1'b0;
          if (finish_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: never more loads than the buffer holds
  a_r4_load_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |-> (ld_q <= (IDX_W+1)'(DEPTH - 1)));
  // R5: wrong confirm code flags both errors and starts nothing
  a_r5_bad_conf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONF && wr_en_i && wr_code_i != CONF_CODE)
      |=> (err_e_q && err_p_q && !start_q && state_q == ST_IDLE));
  // R7: locked block never starts the engine
  a_r7_lock_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONF && wr_en_i && lock_i[blk_q]) |=> !start_q);
  // R2: open code during programming leaves programming running
  a_r2_reject_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !finish_i && wr_en_i) |=> (state_q == ST_PROG));
endmodule

// File: rtl/pbuf_loader.sv
module pbuf_loader
  import pbuf_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int BLK_W = ADDR_W - OFS_W,
  localparam int NBLK  = 1 << BLK_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NBLK-1:0]   lock_i,
  output logic [7:0]        status_o,
  output logic [7:0]        xstatus_o,
  output logic              pe_req_o,
  output logic [ADDR_W-1:0] pe_addr_o,
  output logic [DATA_W-1:0] pe_data_o,
  input  logic              pe_done_i
);
  logic             mem_we, start, finish;
  logic [IDX_W-1:0] widx, ridx, last;
  logic [BLK_W-1:0] blk;
  logic [OFS_W-1:0] rofs;

  pbuf_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i,
    .wr_code_i (wr_data_i[7:0]),
    .lock_i,
    .finish_i  (finish),
    .mem_we_o  (mem_we),
    .mem_idx_o (widx),
    .start_o   (start),
    .last_o    (last),
    .blk_o     (blk),
    .status_o,
    .xstatus_o
  );

  pbuf_mem #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_mem (
    .clk_i, .rst_ni,
    .we_i    (mem_we),
    .widx_i  (widx),
    .wofs_i  (wr_addr_i[OFS_W-1:0]),
    .wdata_i (wr_data_i),
    .ridx_i  (ridx),
    .rofs_o  (rofs),
    .rdata_o (pe_data_o)
  );

  pbuf_issue #(.DEPTH(DEPTH)) u_issue (
    .clk_i, .rst_ni,
    .start_i  (start),
    .last_i   (last),
    .done_i   (pe_done_i),
    .req_o    (pe_req_o),
    .ridx_o   (ridx),
    .finish_o (finish)
  );

  assign pe_addr_o = {blk, rofs};

  // R8: never ready while a word is outstanding
  a_r8_busy_when_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_o |-> !status_o[SR_READY]);
  // R9: address and data stable until done
  a_r9_stable_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_req_o && !pe_done_i) |=> ($stable(pe_addr_o) && $stable(pe_data_o)));
endmodule

// File: tb/pbuf_loader_test.sv
module pbuf_loader_test;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [63:0]   lock = '0;
  logic [7:0]    status, xstatus;
  logic          pe_req, pe_done = 1'b0;
  logic [AW-1:0] pe_addr;
  logic [DW-1:0] pe_data;

  int errors = 0;
  int checks = 0;
  logic [AW+DW-1:0] sbq[$];

  always #2.5 clk = ~clk;

  pbuf_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .lock_i(lock), .status_o(status), .xstatus_o(xstatus),
    .pe_req_o(pe_req), .pe_addr_o(pe_addr), .pe_data_o(pe_data), .pe_done_i(pe_done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int blk, input int ofs);
    return {6'(blk), 16'(ofs)};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // load pairs; push expected items when push_sb
  task automatic load(input int blk, input int n, input int seed, input bit push_sb);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = mk(blk, (seed * 37 + i * 5) & 16'hFFFF);
      d = 16'((seed << 8) ^ (i * 16'h1111) ^ 16'h5A5A);
      if (push_sb) sbq.push_back({a, d});
      wr(a, d);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!status[7] && n < 2000) begin @(negedge clk); n++; end
  endtask

  // engine model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pe_req) begin
        @(negedge clk);
        @(negedge clk);
        if (sbq.size() == 0) begin
          chk(1'b0, "R4 unexpected program request", 64'(pe_addr), 64'd0);
        end else begin
          logic [AW+DW-1:0] e;
          e = sbq.pop_front();
          chk({pe_addr, pe_data} == e, "R4/R9 programmed word", 64'({pe_addr, pe_data}), 64'(e));
        end
        pe_done = 1'b1;
        @(negedge clk);
        pe_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    lock[5] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h80, "R1 reset status", 64'(status), 64'h80);
    chk(xstatus == 8'h00, "R1 reset xstatus", 64'(xstatus), 64'h0);
    chk(!pe_req, "R1 no request at reset", 64'(pe_req), 64'd0);

    // R1 non-open write in idle ignored
    wr(mk(2, 0), 16'h00D0);
    chk(status == 8'h80 && xstatus == 8'h00, "R1 idle write ignored",
        64'({status, xstatus}), 64'h8000);

    // normal 4-word sequence
    wr(mk(2, 0), 16'h00E8);
    chk(xstatus[7], "R1 open accepted", 64'(xstatus), 64'h80);
    wr(mk(2, 0), 16'h0003);
    load(2, 4, 1, 1'b1);
    wr(mk(2, 7), 16'h00D0);
    chk(!status[7], "R8 ready low after confirm", 64'(status[7]), 64'd0);
    // R2 open during programming
    wr(mk(2, 0), 16'h00E8);
    chk(!xstatus[7], "R2 open rejected while busy", 64'(xstatus), 64'h0);
    chk(!status[7], "R2 programming continues", 64'(status[7]), 64'd0);
    wait_ready();
    chk(status == 8'h80, "R8 ready after last word", 64'(status), 64'h80);
    chk(sbq.size() == 0, "R4 all words programmed", 64'(sbq.size()), 64'd0);

    // R3 full buffer with junk high bits in count
    wr(mk(9, 16'h0040), 16'h77E8);
    chk(xstatus[7], "R1 open accepted with high bits", 64'(xstatus), 64'h80);
    wr(mk(9, 0), 16'hAB0F);
    load(9, 16, 2, 1'b1);
    wr(mk(9, 16'h1234), 16'hFFD0);
    chk(!status[7], "R3 16-word sequence started", 64'(status), 64'h00);
    wait_ready();
    chk(status == 8'h80 && sbq.size() == 0, "R3 16 words programmed",
        64'({status, 8'(sbq.size())}), 64'h8000);

    // R5 wrong confirm code
    wr(mk(3, 0), 16'h00E8);
    wr(mk(3, 0), 16'h0001);
    load(3, 2, 3, 1'b0);
    wr(mk(3, 0), 16'h00D1);
    repeat (6) @(negedge clk);
    chk(status == 8'hB0 && !pe_req, "R5 bad confirm code", 64'({status, 7'd0, pe_req}), 64'hB000);

    // R10 open clears errors
    wr(mk(3, 0), 16'h00E8);
    chk(status == 8'h80, "R10 errors cleared by open", 64'(status), 64'h80);
    // R5 confirm in another block
    wr(mk(3, 0), 16'h0000);
    load(3, 1, 4, 1'b0);
    wr(mk(4, 0), 16'h00D0);
    repeat (6) @(negedge clk);
    chk(status == 8'hB0 && !pe_req, "R5 confirm outside block", 64'({status, 7'd0, pe_req}), 64'hB000);

    // R3 count above 15
    wr(mk(3, 0), 16'h00E8);
    wr(mk(3, 0), 16'h0010);
    chk(status == 8'hB0, "R3 count too large", 64'(status), 64'hB0);
    wr(mk(3, 0), 16'h00D0);
    chk(status == 8'hB0 && !pe_req, "R3 sequence ended after bad count", 64'(status), 64'hB0);

    // R6 load outside block
    wr(mk(6, 0), 16'h00E8);
    wr(mk(6, 0), 16'h0002);
    wr(mk(6, 1), 16'h1111);
    wr(mk(7, 2), 16'h2222);
    wr(mk(6, 3), 16'h3333);
    wr(mk(6, 0), 16'h00D0);
    repeat (6) @(negedge clk);
    chk(status == 8'hB0 && !pe_req, "R6 load outside block", 64'({status, 7'd0, pe_req}), 64'hB000);

    // R7 locked block
    wr(mk(5, 0), 16'h00E8);
    chk(status == 8'h80, "R10 errors cleared", 64'(status), 64'h80);
    wr(mk(5, 0), 16'h0001);
    load(5, 2, 5, 1'b0);
    wr(mk(5, 0), 16'h00D0);
    chk(status == 8'h82, "R7 protect set, ready kept", 64'(status), 64'h82);
    repeat (6) @(negedge clk);
    chk(!pe_req && status == 8'h82, "R7 nothing programmed", 64'({status, 7'd0, pe_req}), 64'h8200);

    // R10 protect cleared, single word after lock case
    wr(mk(1, 0), 16'h00E8);
    chk(status == 8'h80 && xstatus[7], "R10 protect cleared", 64'({status, xstatus}), 64'h8080);
    wr(mk(1, 0), 16'h5500);
    load(1, 1, 6, 1'b1);
    wr(mk(1, 0), 16'h00D0);
    wait_ready();
    chk(status == 8'h80 && sbq.size() == 0, "R4 single word", 64'(status), 64'h80);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule